// File: doc/BRIEF.md
# Masked Vector Compress Unit

This unit gathers the mask-selected elements of a source vector and packs them, in their original order, into the lowest element slots of the result. Elements are either bytes or 16-bit words, and the active vector length is a quarter, a half or all of the 512-bit datapath. The packed region is at the bottom of the result. Above it, up to the active length, the result either keeps an old destination value or is cleared. Above the active length it is always zero.

A second output form serves a dense store. It sets a byte enable for each packed byte and for nothing else, so that a downstream write touches only the packed region. Clearing the region above the packed data has no meaning for a store, so asking for zero fill in store form raises an error flag and suppresses every byte enable.

The unit is a single pipeline stage. A request presented with `inValid` is captured on a clock edge, and the result appears with `outValid` one cycle later. Decoding, address generation and the memory side lie outside the block.

Top module: `vcompress_unit`

## Requirements
- R1: Source elements are scanned from index 0 upward, and each selected element is placed in the next free slot of the result, starting at slot 0. The selected elements keep their relative order. For bytes, element j is bits [8j+7:8j]. For words, element j is bits [16j+15:16j].
- R2: `lenSel` sets the active length. 0 gives 128 bits, 1 gives 256 bits, and 2 or 3 give 512 bits. Byte mode has 16, 32 or 64 elements at these lengths, and word mode has 8, 16 or 32.
- R3: `packCount` equals the number of set mask bits among the active elements, where mask bit j belongs to element j. Mask bits at or above the active element count have no effect on any output.
- R4: With `useMask` low, every element within the active length is selected. The result within that length then equals the source, and `packCount` equals the element count.
- R5: In register form (`storeForm` low) with `zeroFill` low, result bytes above the packed region and below the active length equal the same bytes of `oldDest`.
- R6: In register form with `zeroFill` high, result bytes above the packed region and below the active length are zero.
- R7: In register form, result bits at and above the active length are zero.
- R8: `byteEn` has exactly its low (packCount × element bytes) bits set, where element bytes is 1 for bytes and 2 for words. An all-zero selection gives `packCount` 0 and no byte enable.
- R9: In store form, result bytes above the packed region are zero. If `zeroFill` is also high, `storeErr` is 1 and `byteEn` is all zero. In every other case `storeErr` is 0.
- R10: A request with `inValid` high is captured on the rising edge and shown on the outputs, with `outValid` high, for the next cycle. In a cycle after `inValid` was low, `outValid` is low and the data outputs hold their previous values.
- R11: While `rst_n` is low, `outValid`, `resultVec`, `packCount`, `byteEn` and `storeErr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| inValid | input | 1 | Request strobe |
| srcVec | input | 512 | Source vector |
| maskBits | input | 64 | Per-element select, bit j for element j |
| useMask | input | 1 | 1 applies the mask, 0 selects every element |
| wordElem | input | 1 | 0 for byte elements, 1 for 16-bit word elements |
| lenSel | input | 2 | Active length: 0 = 128, 1 = 256, 2 or 3 = 512 bits |
| zeroFill | input | 1 | 1 clears above the packed region, 0 keeps `oldDest` |
| storeForm | input | 1 | 1 selects the dense store form |
| oldDest | input | 512 | Previous destination value, used for merge fill |
| outValid | output | 1 | Result valid |
| resultVec | output | 512 | Packed result |
| packCount | output | 7 | Number of packed elements |
| byteEn | output | 64 | Store byte enables for the packed region |
| storeErr | output | 1 | Zero fill was requested in store form |

## Verification
The bench uses the default width of 64 bytes. At that width all three lengths can be reached, along with the full 64-slot byte case, where the last source byte lands in slot 0 or in slot 63. A quarter-length request then leaves 48 bytes above the active length. This exposes both the clearing above the length and mask bits that must be ignored. Word mode at the same width drives the pairing of mask bits to byte lanes, for up to 32 words.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [1:0] {
    LEN_QUARTER = 2'd0,
    LEN_HALF    = 2'd1,
    LEN_FULL    = 2'd2,
    LEN_FULL_B  = 2'd3
  } vecLen_e;

  typedef struct packed {
    logic capture;
    logic wordMode;
    logic zeroFill;
    logic storeForm;
    logic storeErr;
  } cmpStrobe_t;
endpackage

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
#(
  parameter int VEC_BYTES = 64,
  localparam int CNT_W = $clog2(VEC_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic [VEC_BYTES-1:0] maskBits,
  input  logic                 useMask,
  input  logic                 wordElem,
  input  logic [1:0]           lenSel,
  input  logic                 zeroFill,
  input  logic                 storeForm,
  output cmpStrobe_t           strobe,
  output logic [VEC_BYTES-1:0] byteSel,
  output logic [VEC_BYTES-1:0] laneBytes
);
  logic [CNT_W-1:0] activeBytes;

  always_comb begin
    case (vecLen_e'(lenSel))
      LEN_QUARTER: activeBytes = CNT_W'(VEC_BYTES / 4);
      LEN_HALF:    activeBytes = CNT_W'(VEC_BYTES / 2);
      default:     activeBytes = CNT_W'(VEC_BYTES);
    endcase
  end

  always_comb begin
    for (int b = 0; b < VEC_BYTES; b++) begin
      logic elemOn;
      laneBytes[b] = (CNT_W'(b) < activeBytes);
      if (!useMask)      elemOn = 1'b1;
      else if (wordElem) elemOn = maskBits[b >> 1];
      else               elemOn = maskBits[b];
      byteSel[b] = elemOn & laneBytes[b];
    end
  end

  always_comb begin
    strobe.capture   = inValid;
    strobe.wordMode  = wordElem;
    strobe.zeroFill  = zeroFill;
    strobe.storeForm = storeForm;
    strobe.storeErr  = storeForm & zeroFill;
  end

  // R3
  sel_in_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> ((byteSel & ~laneBytes) == '0));
endmodule

// File: rtl/vcmp_dp.sv
module vcmp_dp
  import vcmp_pkg::*;
#(
  parameter int VEC_BYTES = 64,
  localparam int CNT_W = $clog2(VEC_BYTES + 1),
  localparam int VEC_BITS = VEC_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmpStrobe_t           strobe,
  input  logic [VEC_BYTES-1:0] byteSel,
  input  logic [VEC_BYTES-1:0] laneBytes,
  input  logic [VEC_BITS-1:0]  srcVec,
  input  logic [VEC_BITS-1:0]  oldDest,
  output logic                 outValid,
  output logic [VEC_BITS-1:0]  resultVec,
  output logic [CNT_W-1:0]     packCount,
  output logic [VEC_BYTES-1:0] byteEn,
  output logic                 storeErr
);
  logic [CNT_W-1:0]     slotIdx [VEC_BYTES];
  logic [CNT_W-1:0]     packedBytes;
  logic [7:0]           packedByte [VEC_BYTES];
  logic [VEC_BITS-1:0]  nextRes;
  logic [VEC_BYTES-1:0] nextEn;
  logic [CNT_W-1:0]     nextCnt;
  logic [VEC_BYTES-1:0] laneReg;
  logic                 wordReg;
  logic                 storeReg;

  // prefix popcount: destination slot of every source byte
  always_comb begin
    logic [CNT_W-1:0] run;
    run = '0;
    for (int i = 0; i < VEC_BYTES; i++) begin
      slotIdx[i] = run;
      run = run + CNT_W'(byteSel[i]);
    end
    packedBytes = run;
  end

  // mux network: slot k collects the source byte whose prefix equals k
  always_comb begin
    for (int k = 0; k < VEC_BYTES; k++) begin
      packedByte[k] = 8'h00;
      for (int i = k; i < VEC_BYTES; i++) begin
        if (byteSel[i] && slotIdx[i] == CNT_W'(k))
          packedByte[k] = packedByte[k] | srcVec[i*8 +: 8];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < VEC_BYTES; k++) begin
      if (CNT_W'(k) < packedBytes)
        nextRes[k*8 +: 8] = packedByte[k];
      else if (!strobe.storeForm && laneBytes[k] && !strobe.zeroFill)
        nextRes[k*8 +: 8] = oldDest[k*8 +: 8];
      else
        nextRes[k*8 +: 8] = 8'h00;
      nextEn[k] = (CNT_W'(k) < packedBytes) && !strobe.storeErr;
    end
    nextCnt = strobe.wordMode ? (packedBytes >> 1) : packedBytes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      resultVec <= '0;
      packCount <= '0;
      byteEn    <= '0;
      storeErr  <= 1'b0;
      laneReg   <= '0;
      wordReg   <= 1'b0;
      storeReg  <= 1'b0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        resultVec <= nextRes;
        packCount <= nextCnt;
        byteEn    <= nextEn;
        storeErr  <= strobe.storeErr;
        laneReg   <= laneBytes;
        wordReg   <= strobe.wordMode;
        storeReg  <= strobe.storeForm;
      end
    end
  end

  logic [VEC_BITS-1:0] laneBitsReg;
  always_comb begin
    for (int k = 0; k < VEC_BYTES; k++) laneBitsReg[k*8 +: 8] = {8{laneReg[k]}};
  end

  // R8
  en_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> ((byteEn & (byteEn + VEC_BYTES'(1))) == '0));
  // R8
  en_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !storeErr) |-> ($countones(byteEn) == int'(packCount) * (wordReg ? 2 : 1)));
  // R9
  err_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && storeErr) |-> (byteEn == '0));
  // R7
  above_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !storeReg) |-> ((resultVec & ~laneBitsReg) == '0));
  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> outValid);
endmodule

// File: rtl/vcompress_unit.sv
module vcompress_unit
  import vcmp_pkg::*;
#(
  parameter int VEC_BYTES = 64,
  localparam int CNT_W = $clog2(VEC_BYTES + 1),
  localparam int VEC_BITS = VEC_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic [VEC_BITS-1:0]  srcVec,
  input  logic [VEC_BYTES-1:0] maskBits,
  input  logic                 useMask,
  input  logic                 wordElem,
  input  logic [1:0]           lenSel,
  input  logic                 zeroFill,
  input  logic                 storeForm,
  input  logic [VEC_BITS-1:0]  oldDest,
  output logic                 outValid,
  output logic [VEC_BITS-1:0]  resultVec,
  output logic [CNT_W-1:0]     packCount,
  output logic [VEC_BYTES-1:0] byteEn,
  output logic                 storeErr
);
  cmpStrobe_t           strobe;
  logic [VEC_BYTES-1:0] byteSel;
  logic [VEC_BYTES-1:0] laneBytes;

  vcmp_ctrl #(.VEC_BYTES(VEC_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .maskBits(maskBits),
    .useMask(useMask), .wordElem(wordElem), .lenSel(lenSel),
    .zeroFill(zeroFill), .storeForm(storeForm),
    .strobe(strobe), .byteSel(byteSel), .laneBytes(laneBytes)
  );

  vcmp_dp #(.VEC_BYTES(VEC_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .byteSel(byteSel),
    .laneBytes(laneBytes), .srcVec(srcVec), .oldDest(oldDest),
    .outValid(outValid), .resultVec(resultVec), .packCount(packCount),
    .byteEn(byteEn), .storeErr(storeErr)
  );
endmodule

// File: tb/vcompress_unit_bench.sv
`timescale 1ns/1ps
module vcompress_unit_bench;
  typedef struct packed {
    logic [63:0] mask;
    logic        useM;
    logic        word;
    logic [1:0]  len;
    logic        zf;
    logic        st;
  } vecRow_t;

  localparam int NROWS = 13;
  localparam vecRow_t TAB [NROWS] = '{
    '{64'h8000_0000_0000_0001, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0}, // R1 ends of a full byte vector
    '{64'hFFFF_FFFF_FFFF_00A5, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0}, // R3 high mask ignored, R5 merge
    '{64'h0F0F_0F0F_0F0F_0F0F, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0}, // R6 zero fill, R7 above 256
    '{64'h0000_0000_8000_0003, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0}, // R1 word order
    '{64'hFFFF_FFFF_FFFF_FF5A, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0}, // R3 words, R2 eight words
    '{64'h0000_0000_0000_0000, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0}, // R8 empty selection, R5 merge
    '{64'h0000_0000_0000_0000, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0}, // R4 no mask, bytes
    '{64'h0000_0000_0000_0000, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0}, // R4 no mask, words
    '{64'hF0F0_F0F0_F0F0_F0F0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1}, // R9 store bytes
    '{64'h0000_0000_0000_0033, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1}, // R9 store words
    '{64'h0000_0000_0000_00FF, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1}, // R9 store with zero fill error
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0}, // R2 code 3 is full length
    '{64'h0000_0000_0000_0000, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0}  // R8 empty, R6 all cleared
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic [511:0] srcVec = '0;
  logic [63:0]  maskBits = '0;
  logic         useMask = 1'b0;
  logic         wordElem = 1'b0;
  logic [1:0]   lenSel = '0;
  logic         zeroFill = 1'b0;
  logic         storeForm = 1'b0;
  logic [511:0] oldDest = '0;
  logic         outValid;
  logic [511:0] resultVec;
  logic [6:0]   packCount;
  logic [63:0]  byteEn;
  logic         storeErr;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  vcompress_unit u_vcompress_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .srcVec(srcVec),
    .maskBits(maskBits), .useMask(useMask), .wordElem(wordElem),
    .lenSel(lenSel), .zeroFill(zeroFill), .storeForm(storeForm),
    .oldDest(oldDest), .outValid(outValid), .resultVec(resultVec),
    .packCount(packCount), .byteEn(byteEn), .storeErr(storeErr)
  );

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void refModel(input vecRow_t r, input logic [511:0] src,
                                   input logic [511:0] old, output logic [511:0] res,
                                   output int cnt, output logic [63:0] en, output logic err);
    int esz = r.word ? 2 : 1;
    int kl = (r.len == 2'd0) ? 16 : (r.len == 2'd1) ? 32 : 64;
    int nel = kl / esz;
    int k = 0;
    int nb;
    res = '0;
    for (int j = 0; j < nel; j++) begin
      if (!r.useM || r.mask[j]) begin
        for (int b = 0; b < esz; b++) res[(k*esz+b)*8 +: 8] = src[(j*esz+b)*8 +: 8];
        k++;
      end
    end
    cnt = k;
    nb = k * esz;
    err = r.st && r.zf;
    for (int b = 0; b < 64; b++) begin
      en[b] = (b < nb) && !err;
      if (b >= nb && !r.st && b < kl && !r.zf) res[b*8 +: 8] = old[b*8 +: 8];
    end
  endfunction

  task automatic runRow(input vecRow_t r, input int idx);
    logic [511:0] expRes;
    logic [63:0]  expEn;
    logic         expErr;
    int           expCnt;
    refModel(r, srcVec, oldDest, expRes, expCnt, expEn, expErr);
    @(negedge clk);
    maskBits = r.mask; useMask = r.useM; wordElem = r.word;
    lenSel = r.len; zeroFill = r.zf; storeForm = r.st; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check($sformatf("R10 valid row %0d", idx), 512'(outValid), 512'(1));
    check($sformatf("R1 result row %0d", idx), resultVec, expRes);
    check($sformatf("R3 count row %0d", idx), 512'(packCount), 512'(expCnt));
    check($sformatf("R8 byteEn row %0d", idx), 512'(byteEn), 512'(expEn));
    check($sformatf("R9 error row %0d", idx), 512'(storeErr), 512'(expErr));
  endtask

  initial begin
    #(8 * 100000);
    testsFailed++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      srcVec[i*8 +: 8]  = 8'(i * 37 + 5);
      oldDest[i*8 +: 8] = 8'(8'hC0 ^ i);
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset valid", 512'(outValid), 512'(0));
    check("R11 reset result", resultVec, 512'(0));
    check("R11 reset count/en/err", 512'({packCount, byteEn, storeErr}), 512'(0));
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) runRow(TAB[i], i);

    // R10 hold: no request for a cycle, outputs hold, valid drops
    begin
      logic [511:0] keepRes;
      logic [63:0]  keepEn;
      keepRes = resultVec;
      keepEn = byteEn;
      maskBits = '1;
      @(negedge clk);
      check("R10 valid drops", 512'(outValid), 512'(0));
      check("R10 result holds", resultVec, keepRes);
      check("R10 byteEn holds", 512'(byteEn), 512'(keepEn));
    end

    // R4 no mask equals source within length (full)
    runRow('{64'h0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0}, 100);
    check("R4 result equals source", resultVec, srcVec);
    // R1 last byte alone lands in slot 0
    runRow('{64'h8000_0000_0000_0000, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0}, 101);
    check("R1 last byte to slot 0", resultVec, 512'(srcVec[511:504]));

    for (int n = 0; n < 150; n++) begin
      vecRow_t r;
      r.mask = {$urandom, $urandom};
      r.useM = ($urandom % 8) != 0;
      r.word = 1'($urandom);
      r.len  = 2'($urandom);
      r.zf   = 1'($urandom);
      r.st   = 1'($urandom);
      for (int i = 0; i < 16; i++) begin
        srcVec[i*32 +: 32]  = $urandom;
        oldDest[i*32 +: 32] = $urandom;
      end
      runRow(r, 200 + n);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule